// File: doc/BRIEF.md
# Firmware-Hardware Handshake Control Register

This block is a 32-bit control and status register that boot firmware and a hardware power-management agent use to coordinate memory bring-up. Firmware posts save requests, one per operating point, by writing ones into the low four bits. Each pending request is presented to the agent as a level. The agent clears a request with a one-cycle completion pulse when its save is done, and software sees that clear as the acknowledgement. A write of zero cannot withdraw a request.

When all memory configuration is finished, firmware sets a configuration-done flag. The agent answers on its acknowledge input, and software can read that answer in a separate read-only bit. The cycle in which the acknowledge arrives while the done flag is set, the register locks. From then until reset, software writes have no effect. Completion pulses from the agent still clear any outstanding requests.

Top module: `fw_hw_handshake_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0, `save_pending` is 0, `cfg_done` is 0 and `locked` is 0.
- R2: A cycle with `wr_en` high and `locked` low sets every request bit i (i = 0..3, `rd_data[i]`) for which `wr_data[i]` is 1. The bit reads 1 and `save_pending[i]` is high from the next cycle on.
- R3: Writing 0 to a pending request bit leaves it set.
- R4: A high `save_done[i]` clears request bit i in the next cycle. If a software set of the same bit arrives in the same cycle, the clear wins and the bit reads 0.
- R5: Bit 4 (`rd_data[4]`, mirrored on `cfg_done`) is a read/write flag. While unlocked, a write loads it from `wr_data[4]`, so both 1 and 0 take effect.
- R6: Bit 5 (`rd_data[5]`) shows the value `cfg_ack_in` had in the previous cycle. Software writes never change it.
- R7: `locked` rises in the cycle after `cfg_ack_in` is high while bit 4 reads 1. `cfg_ack_in` has no lock effect while bit 4 is 0. Once high, `locked` stays high until reset.
- R8: While `locked` is high, writes change neither bit 4 nor any request bit. `save_done` pulses still clear request bits.
- R9: Bits 31:6 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| save_pending | output | 4 | Per-operating-point pending save request levels |
| save_done | input | 4 | Per-operating-point save completion pulses from the agent |
| cfg_done | output | 1 | Configuration-done flag presented to the agent |
| cfg_ack_in | input | 1 | Configuration-done acknowledge from the agent |
| locked | output | 1 | Register is locked against software writes |

## Verification
The hardest states to reach are the races. One is a completion pulse landing in the same cycle as a software set of the same bit. The other is a locked register that still has an outstanding request for the agent to clear. The stimulus table drives a write and a completion pulse for bit 3 in one row. Later it leaves bits 0 and 1 pending, sets the done flag and raises the acknowledge. It then tries both setting and clearing through software before the agent's pulses drain the requests. An acknowledge given while the done flag is low checks that the lock needs both conditions. A final reset checks that the lock releases.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int HS_DEF_NUM_SAVE = 4;
  localparam int HS_DEF_DATA_W   = 32;

  // Position of the done flag and its acknowledge relative to the request field
  function automatic int hs_done_pos(input int num_save);
    return num_save;
  endfunction

  function automatic int hs_ack_pos(input int num_save);
    return num_save + 1;
  endfunction
endpackage

// File: rtl/hs_save_bank.sv
module hs_save_bank #(
  parameter int NUM_SAVE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_accept,
  input  logic [NUM_SAVE-1:0] wr_set,
  input  logic [NUM_SAVE-1:0] save_done,
  output logic [NUM_SAVE-1:0] pending
);
  for (genvar g = 0; g < NUM_SAVE; g++) begin : g_req
    logic req_q;

    always_ff @(posedge clk) begin
      if (rst)                         req_q <= 1'b0;
      else if (save_done[g])           req_q <= 1'b0;
      else if (wr_accept && wr_set[g]) req_q <= 1'b1;
    end

    assign pending[g] = req_q;

    // R4: a completion pulse always leaves the bit cleared
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
      save_done[g] |=> !pending[g]);

    // R3: without a completion pulse a pending bit stays pending
    assert_no_sw_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (pending[g] && !save_done[g]) |=> pending[g]);
  end
endmodule

// File: rtl/hs_cfg_lock.sv
module hs_cfg_lock (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_done_bit,
  input  logic ack_in,
  output logic wr_accept,
  output logic cfg_done,
  output logic ack_q,
  output logic locked
);
  logic done_q;
  logic lock_q;

  assign wr_accept = wr_en && !lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      ack_q <= ack_in;
      if (wr_accept)
        done_q <= wr_done_bit;
      if (ack_in && done_q)
        lock_q <= 1'b1;
    end
  end

  assign cfg_done = done_q;
  assign locked   = lock_q;

  // R7: the lock never releases without reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R7: the lock engages only after acknowledge with the done flag set
  assert_lock_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(ack_in) && $past(cfg_done)));

  // R8: the done flag is frozen while locked
  assert_frozen_done_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg_done));
endmodule

// File: rtl/fw_hw_handshake_reg.sv
module fw_hw_handshake_reg
  import hs_pkg::*;
#(
  parameter int NUM_SAVE = HS_DEF_NUM_SAVE,
  parameter int DATA_W   = HS_DEF_DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_SAVE-1:0] save_pending,
  input  logic [NUM_SAVE-1:0] save_done,
  output logic                cfg_done,
  input  logic                cfg_ack_in,
  output logic                locked
);
  localparam int DONE_POS = hs_done_pos(NUM_SAVE);
  localparam int ACK_POS  = hs_ack_pos(NUM_SAVE);
  localparam int RSV_W    = DATA_W - ACK_POS - 1;

  logic wr_accept;
  logic ack_q;
  logic unused_rsv;

  assign unused_rsv = ^wr_data[DATA_W-1:ACK_POS];

  hs_cfg_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_done_bit(wr_data[DONE_POS]),
    .ack_in     (cfg_ack_in),
    .wr_accept  (wr_accept),
    .cfg_done   (cfg_done),
    .ack_q      (ack_q),
    .locked     (locked)
  );

  hs_save_bank #(.NUM_SAVE(NUM_SAVE)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_accept(wr_accept),
    .wr_set   (wr_data[NUM_SAVE-1:0]),
    .save_done(save_done),
    .pending  (save_pending)
  );

  assign rd_data = {{RSV_W{1'b0}}, ack_q, cfg_done, save_pending};

  // R8: no request bit rises while the register is locked
  assert_locked_no_set_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> ((save_pending & ~$past(save_pending)) == '0));
endmodule

// File: tb/sim_fw_hw_handshake_reg.sv
module sim_fw_hw_handshake_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  save_pending;
  logic [3:0]  save_done;
  logic        cfg_done;
  logic        cfg_ack_in;
  logic        locked;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fw_hw_handshake_reg u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .save_pending(save_pending), .save_done(save_done), .cfg_done(cfg_done),
    .cfg_ack_in(cfg_ack_in), .locked(locked)
  );

  // {wr_en, wr_data, save_done, ack_in, expected rd_data, expected locked}
  localparam int NV = 15;
  localparam logic [70:0] TBL [0:NV-1] = '{
    {1'b1, 32'h0000_0005, 4'h0, 1'b0, 32'h0000_0005, 1'b0}, // R2 set 0,2
    {1'b1, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0005, 1'b0}, // R3 zero write
    {1'b1, 32'hFFFF_FFC2, 4'h0, 1'b0, 32'h0000_0007, 1'b0}, // R2 R9 reserved
    {1'b0, 32'h0000_0000, 4'h1, 1'b0, 32'h0000_0006, 1'b0}, // R4 clear bit0
    {1'b1, 32'h0000_0008, 4'h8, 1'b0, 32'h0000_0006, 1'b0}, // R4 race bit3
    {1'b0, 32'h0000_0000, 4'h6, 1'b0, 32'h0000_0000, 1'b0}, // R4 clear 1,2
    {1'b0, 32'h0000_0000, 4'h0, 1'b1, 32'h0000_0020, 1'b0}, // R6 R7 ack w/o done
    {1'b1, 32'h0000_0010, 4'h0, 1'b0, 32'h0000_0010, 1'b0}, // R5 set done
    {1'b1, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0000, 1'b0}, // R5 clear done
    {1'b1, 32'h0000_0013, 4'h0, 1'b0, 32'h0000_0013, 1'b0}, // R2 R5
    {1'b0, 32'h0000_0000, 4'h0, 1'b1, 32'h0000_0033, 1'b1}, // R7 lock
    {1'b1, 32'h0000_002C, 4'h0, 1'b0, 32'h0000_0013, 1'b1}, // R8 R6 no set
    {1'b1, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0013, 1'b1}, // R8 no clear
    {1'b0, 32'h0000_0000, 4'h3, 1'b0, 32'h0000_0010, 1'b1}, // R8 hw clears
    {1'b0, 32'h0000_0000, 4'h0, 1'b0, 32'h0000_0010, 1'b1}  // R7 sticky
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic [3:0] sd, input logic ak);
    @(negedge clk);
    wr_en = we; wr_data = wd; save_done = sd; cfg_ack_in = ak;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req, input logic [31:0] exp_rd, input logic exp_lock);
    check32(req, rd_data, exp_rd);
    check32(req, {28'h0, save_pending}, {28'h0, exp_rd[3:0]});
    check32(req, {31'h0, cfg_done}, {31'h0, exp_rd[4]});
    check32(req, {31'h0, locked}, {31'h0, exp_lock});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; save_done = '0; cfg_ack_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1 reset", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][70], TBL[i][69:38], TBL[i][37:34], TBL[i][33]);
      check_all($sformatf("R2-table row %0d", i), TBL[i][32:1], TBL[i][0]);
    end

    // R1 R7: reset releases the lock and clears everything
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; save_done = '0; cfg_ack_in = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1 R7 reset unlock", 32'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R2: writes accepted again after reset
    step(1'b1, 32'h0000_0009, 4'h0, 1'b0);
    check_all("R2 after unlock", 32'h0000_0009, 1'b0);
    // R9: reserved-only write has no effect
    step(1'b1, 32'hFFFF_FFC0, 4'h0, 1'b0);
    check_all("R9 reserved only", 32'h0000_0009, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule